// File: doc/BRIEF.md
# Supervisory Reset Generator with Data-Line Watchdog

This block drives the active-low system reset for a small serial-memory style device. Two conditions pull reset low. The first is a digital power-good flag from an analog comparator that reports a supply below its trip level. The second is a watchdog that watches the serial data line of the two-wire bus. A healthy bus master toggles that line, and each toggle restarts the watchdog. If the line stays at one level, either high or low, for longer than the selected period, the watchdog fires.

After any cause of reset ends, reset stays low for one fixed hold period and then releases. The cause may be power-up, a brown-out, or a watchdog trip. The power-good flag and the data line each pass through a two-flop synchronizer. A low power-good level also clears the block at once, with no clock needed. The watchdog runs only while it is enabled. A 2-bit select chooses one of four timeouts, and each timeout is a parameter counted in clock cycles. The defaults are scaled down so that simulation runs fast.

Top module: `sup_rst_wdog`

## Requirements
- R1: While `pwr_good` is low, `rst_n` is low. `rst_n` goes low as soon as `pwr_good` falls, without waiting for a clock edge.
- R2: Call the first rising clock edge after `pwr_good` returns high edge 0. `rst_n` is still low after HOLD_CYC+1 edges (edges 0 to HOLD_CYC) and is high after edge HOLD_CYC+1.
- R3: At power-up `rst_n` is low while `pwr_good` is low. After the first rise of `pwr_good`, `rst_n` releases with the same timing as in R2.
- R4: With `wdt_en` high and `sda_in` stuck high, the watchdog pulls `rst_n` low at edge T+2. Edge 0 is the first rising edge after the last change of `sda_in`, and T is the selected timeout.
- R5: The watchdog behaves as in R4 when `sda_in` is stuck low.
- R6: `wdt_sel` values 0, 1, 2 and 3 select the timeouts TMO0_CYC, TMO1_CYC, TMO2_CYC and TMO3_CYC.
- R7: After a watchdog trip, `rst_n` stays low for exactly HOLD_CYC cycles. While it is low the watchdog count is held at zero. If `sda_in` is still stuck, the next trip comes exactly T cycles after release.
- R8: While `wdt_en` is low, a stuck `sda_in` never pulls `rst_n` low.
- R9: If `pwr_good` drops during a hold period, the hold restarts from zero. The release then follows the timing of R2, counted from the latest return of `pwr_good`.
- R10: If `sda_in` changes at intervals shorter than the selected timeout, `rst_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_good | input | 1 | Asynchronous flag, high while the supply is above the trip level |
| sda_in | input | 1 | Sampled level of the serial data line |
| wdt_en | input | 1 | Watchdog enable, active high |
| wdt_sel | input | 2 | Timeout select, 0 to 3 |
| rst_n | output | 1 | System reset, active low |

## Verification
The hardest case to reach is the second watchdog trip in R7. It needs a first trip, a full hold period, and then a release with the data line still frozen, so that the next trip can be timed from the release edge. Each watchdog scenario disables the watchdog first and parks the line at the opposite level. It then makes a single change of the line at a known negative edge and re-enables the watchdog in the same cycle. Holding the line there gives exact cycle counts for the first trip, the hold, and the second trip. A second hard case is the R9 restart. Here `pwr_good` is dropped for one cycle in the middle of a hold, and the release is timed from the latest rise.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        TMO_SEL0 = 2'd0,
        TMO_SEL1 = 2'd1,
        TMO_SEL2 = 2'd2,
        TMO_SEL3 = 2'd3
    } tmo_sel_e;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (e > m) m = e;
        return m;
    endfunction

    function automatic int unsigned pick_tmo(input logic [1:0] sel,
                                             input int unsigned t0, input int unsigned t1,
                                             input int unsigned t2, input int unsigned t3);
        case (tmo_sel_e'(sel))
            TMO_SEL0: return t0;
            TMO_SEL1: return t1;
            TMO_SEL2: return t2;
            default:  return t3;
        endcase
    endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter int unsigned W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sync_q <= {(2 * W){RST_VAL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.s2;

endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
    parameter int unsigned HOLD_CYC = 250
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic pg_ok,
    input  logic wdt_fire,
    output logic rst_n
);

    localparam int unsigned    CW   = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0]  LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          rst_n;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (!pg_ok) begin
            hold_d.rst_n = 1'b0;
            hold_d.cnt   = '0;
        end else if (!hold_q.rst_n) begin
            if (hold_q.cnt >= LAST) begin
                hold_d.rst_n = 1'b1;
                hold_d.cnt   = '0;
            end else begin
                hold_d.cnt = hold_q.cnt + 1'b1;
            end
        end else if (wdt_fire) begin
            hold_d.rst_n = 1'b0;
            hold_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign rst_n = hold_q.rst_n;

endmodule

// File: rtl/sup_sda_wdt.sv
module sup_sda_wdt #(
    parameter int unsigned TMO0_CYC = 40,
    parameter int unsigned TMO1_CYC = 80,
    parameter int unsigned TMO2_CYC = 160,
    parameter int unsigned TMO3_CYC = 320
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       sda_s,
    input  logic       wdt_en,
    input  logic [1:0] wdt_sel,
    input  logic       rst_n,
    output logic       wdt_fire
);

    import sup_pkg::*;

    localparam int unsigned MAXT = max_of4(TMO0_CYC, TMO1_CYC, TMO2_CYC, TMO3_CYC);
    localparam int unsigned CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(MAXT);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } wdt_t;

    wdt_t          wdt_d, wdt_q;
    logic          line_moved;
    logic [CW-1:0] limit;
    logic [CW-1:0] lim_tab [4];

    genvar gi;
    generate
        for (gi = 0; gi < 4; gi++) begin : g_lim
            assign lim_tab[gi] = CW'(pick_tmo(2'(gi), TMO0_CYC, TMO1_CYC, TMO2_CYC, TMO3_CYC) - 1);
        end
    endgenerate

    assign limit      = lim_tab[wdt_sel];
    assign line_moved = sda_s ^ wdt_q.prev;
    assign wdt_fire   = wdt_en & rst_n & ~line_moved & (wdt_q.cnt >= limit);

    always_comb begin
        wdt_d      = wdt_q;
        wdt_d.prev = sda_s;
        if (!wdt_en || !rst_n || line_moved || wdt_fire) begin
            wdt_d.cnt = '0;
        end else if (wdt_q.cnt < CNT_TOP) begin
            wdt_d.cnt = wdt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            wdt_q <= '0;
        end else begin
            wdt_q <= wdt_d;
        end
    end

endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog #(
    parameter int unsigned HOLD_CYC = 250,
    parameter int unsigned TMO0_CYC = 40,
    parameter int unsigned TMO1_CYC = 80,
    parameter int unsigned TMO2_CYC = 160,
    parameter int unsigned TMO3_CYC = 320
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       sda_in,
    input  logic       wdt_en,
    input  logic [1:0] wdt_sel,
    output logic       rst_n
);

    logic pg_ok;
    logic sda_sync;
    logic wdt_fire;

    sup_sync2 #(.W(1), .RST_VAL(1'b0)) u_pg_sync (
        .clk   (clk),
        .clr_n (pwr_good),
        .din   (1'b1),
        .dout  (pg_ok)
    );

    sup_sync2 #(.W(1), .RST_VAL(1'b1)) u_sda_sync (
        .clk   (clk),
        .clr_n (pwr_good),
        .din   (sda_in),
        .dout  (sda_sync)
    );

    sup_sda_wdt #(
        .TMO0_CYC (TMO0_CYC),
        .TMO1_CYC (TMO1_CYC),
        .TMO2_CYC (TMO2_CYC),
        .TMO3_CYC (TMO3_CYC)
    ) u_wdt (
        .clk      (clk),
        .pwr_good (pwr_good),
        .sda_s    (sda_sync),
        .wdt_en   (wdt_en),
        .wdt_sel  (wdt_sel),
        .rst_n    (rst_n),
        .wdt_fire (wdt_fire)
    );

    sup_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .pwr_good (pwr_good),
        .pg_ok    (pg_ok),
        .wdt_fire (wdt_fire),
        .rst_n    (rst_n)
    );

endmodule

// File: rtl/sup_rst_chk.sv
module sup_rst_chk #(
    parameter int unsigned HOLD_CYC = 250,
    parameter int unsigned TMO0_CYC = 40,
    parameter int unsigned TMO1_CYC = 80,
    parameter int unsigned TMO2_CYC = 160,
    parameter int unsigned TMO3_CYC = 320
) (
    input logic       clk,
    input logic       pwr_good,
    input logic       sda_s,
    input logic       wdt_en,
    input logic [1:0] wdt_sel,
    input logic       rst_n
);

    import sup_pkg::*;

    localparam int unsigned MAXT = max_of4(TMO0_CYC, TMO1_CYC, TMO2_CYC, TMO3_CYC);
    localparam int unsigned LW   = $clog2(HOLD_CYC + 2);
    localparam int unsigned SW   = $clog2(MAXT + 2);

    logic [LW-1:0] low_run;
    logic [SW-1:0] still_run;
    logic          sda_seen;

    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            low_run   <= '0;
            still_run <= '0;
            sda_seen  <= sda_s;
        end else begin
            sda_seen <= sda_s;
            if (rst_n) begin
                low_run <= '0;
            end else if (low_run <= LW'(HOLD_CYC)) begin
                low_run <= low_run + 1'b1;
            end
            if (sda_s != sda_seen) begin
                still_run <= '0;
            end else if (still_run <= SW'(MAXT)) begin
                still_run <= still_run + 1'b1;
            end
        end
    end

    // R1: power-bad forces reset
    p_bo_low_r1: assert property (@(posedge clk) !pwr_good |-> !rst_n);

    // R2: release only after a full hold
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(rst_n) |-> (low_run >= LW'(HOLD_CYC)));

    // R7: a trip never yields a one-cycle pulse
    p_trip_min_r7: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(rst_n) |=> !rst_n);

    // R8: no trip while disabled
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(rst_n) |-> $past(wdt_en));

    // R4: a trip needs the line frozen for the selected period
    p_frozen_line_r4: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(rst_n) |-> (32'(still_run) + 1 >=
            pick_tmo($past(wdt_sel), TMO0_CYC, TMO1_CYC, TMO2_CYC, TMO3_CYC)));

endmodule

bind sup_rst_wdog sup_rst_chk #(
    .HOLD_CYC (HOLD_CYC),
    .TMO0_CYC (TMO0_CYC),
    .TMO1_CYC (TMO1_CYC),
    .TMO2_CYC (TMO2_CYC),
    .TMO3_CYC (TMO3_CYC)
) u_chk (
    .clk      (clk),
    .pwr_good (pwr_good),
    .sda_s    (sda_sync),
    .wdt_en   (wdt_en),
    .wdt_sel  (wdt_sel),
    .rst_n    (rst_n)
);

// File: tb/sim_sup_rst_wdog.sv
module sim_sup_rst_wdog;

    localparam int CLK_NS = 10;
    localparam int HOLD   = 50;
    localparam int T0     = 20;
    localparam int T1     = 30;
    localparam int T2     = 45;
    localparam int T3     = 70;

    logic       clk      = 1'b0;
    logic       pwr_good = 1'b0;
    logic       sda_in   = 1'b1;
    logic       wdt_en   = 1'b0;
    logic [1:0] wdt_sel  = 2'd0;
    logic       rst_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sup_rst_wdog #(
        .HOLD_CYC (HOLD),
        .TMO0_CYC (T0),
        .TMO1_CYC (T1),
        .TMO2_CYC (T2),
        .TMO3_CYC (T3)
    ) u0 (
        .clk      (clk),
        .pwr_good (pwr_good),
        .sda_in   (sda_in),
        .wdt_en   (wdt_en),
        .wdt_sel  (wdt_sel),
        .rst_n    (rst_n)
    );

    function automatic int tmo_of(input int s);
        case (s)
            0:       return T0;
            1:       return T1;
            2:       return T2;
            default: return T3;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rst_n=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Called on the negedge at which pwr_good has just risen
    task automatic expect_release(input string tag);
        repeat (HOLD + 1) @(posedge clk);
        @(negedge clk);
        check({tag, " still held"}, rst_n, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " released"}, rst_n, 1'b1);
    endtask

    task automatic t_powerup();
        repeat (5) @(negedge clk);
        check("R1 low while power bad", rst_n, 1'b0);
        check("R3 held at power-up", rst_n, 1'b0);
        pwr_good = 1'b1;
        expect_release("R3");
    endtask

    task automatic t_disabled();
        bit ok = 1'b1;
        @(negedge clk);
        wdt_en = 1'b0;
        sda_in = 1'b0;
        repeat (3 * T3) begin
            @(negedge clk);
            if (rst_n !== 1'b1) ok = 1'b0;
        end
        check("R8 no trip while disabled", ok, 1'b1);
    endtask

    task automatic t_toggle();
        bit ok = 1'b1;
        @(negedge clk);
        wdt_sel = 2'd0;
        wdt_en  = 1'b1;
        repeat (20) begin
            repeat (T0 / 2) begin
                @(negedge clk);
                if (rst_n !== 1'b1) ok = 1'b0;
            end
            sda_in = ~sda_in;
        end
        check("R10 active line keeps reset high", ok, 1'b1);
        wdt_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_wdt(input int sel, input logic level, input string tag);
        int t;
        t = tmo_of(sel);
        @(negedge clk);
        wdt_en  = 1'b0;
        wdt_sel = 2'(sel);
        sda_in  = ~level;
        repeat (4) @(negedge clk);
        sda_in = level;
        wdt_en = 1'b1;
        repeat (t + 2) @(posedge clk);
        @(negedge clk);
        check({tag, " high before timeout"}, rst_n, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check({tag, " trip at timeout"}, rst_n, 1'b0);
        repeat (HOLD - 1) @(posedge clk);
        @(negedge clk);
        check("R7 low through hold", rst_n, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R7 release after hold", rst_n, 1'b1);
        repeat (t - 1) @(posedge clk);
        @(negedge clk);
        check("R7 high before second trip", rst_n, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check("R7 second trip", rst_n, 1'b0);
        wdt_en = 1'b0;
        repeat (HOLD + 4) @(negedge clk);
        check("R8 recovered with watchdog off", rst_n, 1'b1);
    endtask

    task automatic t_brownout();
        @(negedge clk);
        pwr_good = 1'b0;
        #1;
        check("R1 immediate assert", rst_n, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 stays low", rst_n, 1'b0);
        pwr_good = 1'b1;
        expect_release("R2");
    endtask

    task automatic t_glitch();
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        repeat (HOLD / 2) @(negedge clk);
        check("R9 mid-hold low", rst_n, 1'b0);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        expect_release("R9");
    endtask

    initial begin
        t_powerup();
        t_disabled();
        t_toggle();
        t_wdt(0, 1'b1, "R4/R6 sel0 stuck high");
        t_wdt(1, 1'b0, "R5/R6 sel1 stuck low");
        t_wdt(2, 1'b1, "R4/R6 sel2 stuck high");
        t_wdt(3, 1'b0, "R5/R6 sel3 stuck low");
        t_brownout();
        t_glitch();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

endmodule